// File: doc/BRIEF.md
# Windowed Watchdog Timer with Two-Step Key Service

The block is a watchdog that must be serviced by software inside a time window. An 8-bit up-counter advances once per watchdog tick. The tick comes from a power-of-two divider chain placed after the block clock, which stands for the watchdog oscillator. Software restarts the counter by writing an arming key and then a firing key to the key register. If the counter wraps past its maximum, or if service arrives before the counter has reached a programmable lower bound, the block raises a timeout event. A malformed write to the control register raises the same event.

Each event produces one fixed-length pulse, and a mode bit chooses its form. In reset mode the block drives an active-high reset request and sets a sticky cause flag. In interrupt mode it drives an active-low interrupt request. Software can disable the watchdog only while a one-shot lock bit is still open. Once the lock is closed, the disable setting is frozen until the next reset. A simple single-cycle write port and a combinational read port give access to five registers: status, counter, key, control and window.

Top module: `winwdog_top`

## Requirements
- R1: The counter advances by 1 per tick and starts at 0 after reset. Ticks are spaced 2^E clock cycles apart, with E = Epre + Eps. Control bits [12:9] select Epre: codes 0..3 give 9..12, codes 8..15 give 1..8, and the unused codes 4..7 give 9. Control bits [8:6] select Eps: codes 0 and 1 give 0, and code n>=2 gives n-1. The reset values give E = 9.
- R2: When a tick arrives with the counter at 255 and the watchdog enabled, the counter wraps to 0 and a timeout event is raised. Status bit 1 selects the event kind and resets to 0. A value of 0 means reset request and 1 means interrupt.
- R3: Writing 0x55 to the key register (address 2) arms the key. A following key write of 0xAA clears the counter to 0 on that clock edge and disarms the key. Any other key value, including an 0xAA that is not armed, leaves the counter alone and disarms a pending 0x55. Writes to other registers do not change the armed state.
- R4: A valid service raises a timeout event when the counter is below the window threshold, which is window register bits [7:0] at address 4. With a threshold of 0 no service ever raises an event.
- R5: Every control write (address 3) must carry 3'b101 in bits [5:3]. A control write with any other value raises a timeout event and changes no control field. Bits [5:3] always read back as 0.
- R6: The lock bit is status bit 0. It resets to 1, and writing 1 to it clears it. Writing 0 to it has no effect, and once cleared it stays cleared until reset. The disable bit, control bit 0, changes on a valid control write only while the lock bit is 1.
- R7: The disable bit resets to 0, so the watchdog starts enabled. While the watchdog is disabled the counter holds at 0 and no timeout event is raised from any source.
- R8: An event raised while no pulse is active starts a pulse of PULSE_LEN cycles. The pulse is `wdog_rst` high in reset mode or `wdog_irq_n` low in interrupt mode, and it begins one cycle after the event. Events raised during a pulse are ignored. Status bit 2 reads the level of `wdog_irq_n` one cycle late and resets to 1.
- R9: Control bit 1 is the cause flag. It sets when a reset-kind pulse starts. A valid control write with bit 1 equal to 1 clears it, and a write with bit 1 equal to 0 leaves it unchanged. If a set and a clear happen in the same cycle, the set wins.
- R10: Window bit 8 reads the first-key flag. It sets on a valid service while the threshold is non-zero and stays 0 while the threshold is 0. It clears on the same edge on which the threshold is written to 0.
- R11: A read of the key register returns the control register contents. The control register reads {3'b0, pre[3:0], ps[2:0], 3'b000, 1'b0, flag, disable}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the watchdog oscillator |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| addr | input | 3 | Register address: 0 status, 1 counter, 2 key, 3 control, 4 window |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr`, combinational |
| wdog_rst | output | 1 | Reset request pulse, active high |
| wdog_irq_n | output | 1 | Interrupt request pulse, active low |

## Verification
The embedded assertions check the cycle-level invariants on every cycle:
- The lock bit stays closed once cleared, and the disable bit is frozen while it is closed.
- The cause flag is sticky, and the first-key flag stays 0 while the threshold is 0.
- The counter reads 0 after a service or while disabled.
- Ticks are spaced apart.
- The two outputs are never active together.
- An overflow or an early service starts a pulse one cycle later.

Only the bench scenarios, compared against a behavioural model on every clock, can show the remaining behaviours:
- The key ordering and disarm rules across several writes.
- The exact tick period for each divider code.
- The pulse length.
- The discarding of a control write with bad check bits.
- The window accepting a late service.
- The lock blocking a re-enable.

// File: rtl/winwdog_pkg.sv
// Package: shared constants, register addresses, field positions and the
// divider exponent decode for the windowed watchdog.
// Assumes: 16-bit register port, 3-bit address.
package winwdog_pkg;

    localparam int DATA_W  = 16;
    localparam int ADDR_W  = 3;
    localparam int MAX_EXP = 18;
    localparam int EXP_W   = $clog2(MAX_EXP + 1);

    typedef enum logic [ADDR_W-1:0] {
        REG_STAT = 3'd0,
        REG_CNT  = 3'd1,
        REG_KEY  = 3'd2,
        REG_CTRL = 3'd3,
        REG_WIN  = 3'd4
    } reg_addr_e;

    localparam logic [7:0] KEY_ARM  = 8'h55;
    localparam logic [7:0] KEY_FIRE = 8'hAA;
    localparam logic [2:0] CHK_PATTERN = 3'b101;

    // control field positions
    localparam int CTRL_DIS    = 0;
    localparam int CTRL_FLAG   = 1;
    localparam int CTRL_CHK_LO = 3;
    localparam int CTRL_PS_LO  = 6;
    localparam int CTRL_PRE_LO = 9;

    // status field positions
    localparam int STAT_LOCK = 0;
    localparam int STAT_MODE = 1;
    localparam int STAT_IRQ  = 2;

    // Total divider exponent from the pre-divider and prescaler codes.
    function automatic logic [EXP_W-1:0] div_exponent(input logic [3:0] pre,
                                                      input logic [2:0] ps);
        logic [EXP_W-1:0] e_pre;
        logic [EXP_W-1:0] e_ps;
        if (pre[3])
            e_pre = EXP_W'(pre[2:0]) + EXP_W'(1);
        else if (pre[2])
            e_pre = EXP_W'(9);
        else
            e_pre = EXP_W'(9) + EXP_W'(pre[1:0]);
        e_ps = (ps <= 3'd1) ? '0 : EXP_W'(ps) - EXP_W'(1);
        return e_pre + e_ps;
    endfunction

endpackage

// File: rtl/winwdog_prediv.sv
// Module: winwdog_prediv
// Produces a one-cycle tick every 2^exp_sel clock cycles while run is high.
// Assumes: exp_sel <= MAX_EXP; a lowered run restarts the phase at zero.
module winwdog_prediv #(
    parameter int MAX_EXP = 18,
    parameter int EXP_W   = $clog2(MAX_EXP + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [EXP_W-1:0] exp_sel,
    output logic             tick
);
    localparam int DIV_W = MAX_EXP + 1;

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] limit;

    // Terminal count for the selected power of two.
    always_comb limit = (DIV_W'(1) << exp_sel) - DIV_W'(1);

    assign tick = run && (div_q >= limit);

    // Phase counter: restarts on each tick or while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n)
            div_q <= '0;
        else if (!run || tick)
            div_q <= '0;
        else
            div_q <= div_q + DIV_W'(1);
    end

    p_tick_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (!tick || limit == '0));

endmodule

// File: rtl/winwdog_regs.sv
// Module: winwdog_regs
// Register file: status, key sequencer, control with check-bit gate and
// disable lock, window threshold, first-key flag, cause flag and the read
// multiplexer.
// Assumes: one write per cycle; reads are combinational.
module winwdog_regs
    import winwdog_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int STS_SYNC = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              rst_evt,
    input  logic              irq_n,
    output logic [DATA_W-1:0] rdata,
    output logic              wd_en,
    output logic              irq_mode,
    output logic [EXP_W-1:0]  exp_sel,
    output logic [CNT_W-1:0]  min_thr,
    output logic              svc_ok,
    output logic              chk_bad
);
    localparam int WIN_FIRST = CNT_W;

    logic             lock_q, mode_q, dis_q, flag_q, armed_q, first_q;
    logic [2:0]       ps_q;
    logic [3:0]       pre_q;
    logic [CNT_W-1:0] min_q;
    logic [CNT_W-1:0] min_next;
    logic [STS_SYNC-1:0] sts_q;
    logic             wr_stat, wr_key, wr_ctrl, wr_win, chk_ok, ctrl_ok;
    logic             unused_ok;

    assign unused_ok = ^{wdata[DATA_W-1:13], wdata[2]};

    // Write decode per register.
    always_comb begin
        wr_stat = wr_en && (addr == REG_STAT);
        wr_key  = wr_en && (addr == REG_KEY);
        wr_ctrl = wr_en && (addr == REG_CTRL);
        wr_win  = wr_en && (addr == REG_WIN);
        chk_ok  = wdata[CTRL_CHK_LO +: 3] == CHK_PATTERN;
        ctrl_ok = wr_ctrl && chk_ok;
        chk_bad = wr_ctrl && !chk_ok;
        svc_ok  = wr_key && (wdata[7:0] == KEY_FIRE) && armed_q;
        min_next = wr_win ? wdata[CNT_W-1:0] : min_q;
    end

    // Status: one-shot lock and event-kind select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q <= 1'b1;
            mode_q <= 1'b0;
        end else if (wr_stat) begin
            if (wdata[STAT_LOCK]) lock_q <= 1'b0;
            mode_q <= wdata[STAT_MODE];
        end
    end

    // Control fields: only accepted with a correct check pattern.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dis_q <= 1'b0;
            ps_q  <= '0;
            pre_q <= '0;
        end else if (ctrl_ok) begin
            ps_q  <= wdata[CTRL_PS_LO +: 3];
            pre_q <= wdata[CTRL_PRE_LO +: 4];
            if (lock_q) dis_q <= wdata[CTRL_DIS];
        end
    end

    // Cause flag: set by a reset-kind pulse, cleared by writing one.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (rst_evt)
            flag_q <= 1'b1;
        else if (ctrl_ok && wdata[CTRL_FLAG])
            flag_q <= 1'b0;
    end

    // Key sequencer: any key write re-evaluates the armed state.
    always_ff @(posedge clk) begin
        if (!rst_n)
            armed_q <= 1'b0;
        else if (wr_key)
            armed_q <= (wdata[7:0] == KEY_ARM);
    end

    // Window threshold and first-key flag, updated on the same edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            min_q   <= '0;
            first_q <= 1'b0;
        end else begin
            min_q <= min_next;
            if (min_next == '0)
                first_q <= 1'b0;
            else if (svc_ok)
                first_q <= 1'b1;
        end
    end

    // Interrupt level sampled into the status register.
    generate
        if (STS_SYNC == 1) begin : g_sts_one
            always_ff @(posedge clk) begin
                if (!rst_n) sts_q <= '1;
                else        sts_q <= irq_n;
            end
        end else begin : g_sts_chain
            always_ff @(posedge clk) begin
                if (!rst_n) sts_q <= '1;
                else        sts_q <= {sts_q[STS_SYNC-2:0], irq_n};
            end
        end
    endgenerate

    // Read multiplexer; the key address mirrors control.
    always_comb begin
        rdata = '0;
        case (addr)
            REG_STAT: begin
                rdata[STAT_LOCK] = lock_q;
                rdata[STAT_MODE] = mode_q;
                rdata[STAT_IRQ]  = sts_q[STS_SYNC-1];
            end
            REG_CNT: rdata[CNT_W-1:0] = cnt;
            REG_KEY, REG_CTRL: begin
                rdata[CTRL_DIS]          = dis_q;
                rdata[CTRL_FLAG]         = flag_q;
                rdata[CTRL_PS_LO +: 3]   = ps_q;
                rdata[CTRL_PRE_LO +: 4]  = pre_q;
            end
            REG_WIN: begin
                rdata[CNT_W-1:0] = min_q;
                rdata[WIN_FIRST] = first_q;
            end
            default: rdata = '0;
        endcase
    end

    assign wd_en    = !dis_q;
    assign irq_mode = mode_q;
    assign exp_sel  = div_exponent(pre_q, ps_q);
    assign min_thr  = min_q;

    p_lock_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_q |=> !lock_q);
    p_dis_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_q |=> $stable(dis_q));
    p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !(ctrl_ok && wdata[CTRL_FLAG])) |=> flag_q);
    p_first_needs_min_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (min_q == '0) |-> !first_q);

endmodule

// File: rtl/winwdog_core.sv
// Module: winwdog_core
// Watchdog counter, window check, event merge and the output pulse timer.
// Assumes: svc_ok and chk_bad are single-cycle strobes from the register
// file; tick is already gated by the enable.
module winwdog_core #(
    parameter int CNT_W     = 8,
    parameter int PULSE_LEN = 512
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wd_en,
    input  logic             tick,
    input  logic             svc_ok,
    input  logic             chk_bad,
    input  logic [CNT_W-1:0] min_thr,
    input  logic             irq_mode,
    output logic [CNT_W-1:0] cnt,
    output logic             rst_evt,
    output logic             wdog_rst,
    output logic             wdog_irq_n
);
    localparam int PLS_W = $clog2(PULSE_LEN + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [PLS_W-1:0] pls_q;
    logic             kind_q;
    logic             early, ovf, evt, start, busy;

    // Event sources merged and gated by the enable.
    always_comb begin
        busy  = (pls_q != '0);
        early = svc_ok && (cnt_q < min_thr);
        ovf   = tick && (&cnt_q) && !svc_ok;
        evt   = wd_en && (ovf || early || chk_bad);
        start = evt && !busy;
    end

    // Counter: held while disabled, cleared by service, else counts ticks.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!wd_en || svc_ok)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= cnt_q + CNT_W'(1);
    end

    // Pulse timer: loads on a new event, counts down to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pls_q  <= '0;
            kind_q <= 1'b0;
        end else if (start) begin
            pls_q  <= PLS_W'(PULSE_LEN);
            kind_q <= irq_mode;
        end else if (busy) begin
            pls_q <= pls_q - PLS_W'(1);
        end
    end

    assign cnt        = cnt_q;
    assign rst_evt    = start && !irq_mode;
    assign wdog_rst   = busy && !kind_q;
    assign wdog_irq_n = !(busy && kind_q);

    p_svc_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_ok && wd_en) |=> (cnt_q == '0));
    p_off_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wd_en |=> (cnt_q == '0));
    p_one_output_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(wdog_rst && !wdog_irq_n));
    p_ovf_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_en && tick && (&cnt_q) && !svc_ok && !busy) |=> (wdog_rst || !wdog_irq_n));
    p_early_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_en && svc_ok && (cnt_q < min_thr) && !busy) |=> (wdog_rst || !wdog_irq_n));

endmodule

// File: rtl/winwdog_top.sv
// Module: winwdog_top
// Windowed watchdog: divider, register file and counter/event core.
// Assumes: clk is the watchdog oscillator and the register port clock;
// wdog_rst is not looped back into rst_n of this block.
module winwdog_top
    import winwdog_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int PULSE_LEN = 512,
    parameter int STS_SYNC  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              wdog_rst,
    output logic              wdog_irq_n
);
    logic             wd_en, irq_mode, svc_ok, chk_bad, tick, rst_evt;
    logic [EXP_W-1:0] exp_sel;
    logic [CNT_W-1:0] min_thr, cnt;

    winwdog_prediv #(.MAX_EXP(MAX_EXP), .EXP_W(EXP_W)) u_div (
        .clk(clk), .rst_n(rst_n), .run(wd_en), .exp_sel(exp_sel), .tick(tick)
    );

    winwdog_regs #(.CNT_W(CNT_W), .STS_SYNC(STS_SYNC)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .cnt(cnt), .rst_evt(rst_evt), .irq_n(wdog_irq_n), .rdata(rdata),
        .wd_en(wd_en), .irq_mode(irq_mode), .exp_sel(exp_sel),
        .min_thr(min_thr), .svc_ok(svc_ok), .chk_bad(chk_bad)
    );

    winwdog_core #(.CNT_W(CNT_W), .PULSE_LEN(PULSE_LEN)) u_core (
        .clk(clk), .rst_n(rst_n), .wd_en(wd_en), .tick(tick), .svc_ok(svc_ok),
        .chk_bad(chk_bad), .min_thr(min_thr), .irq_mode(irq_mode), .cnt(cnt),
        .rst_evt(rst_evt), .wdog_rst(wdog_rst), .wdog_irq_n(wdog_irq_n)
    );

endmodule

// File: tb/winwdog_top_test.sv
module winwdog_top_test;
    localparam int PLS = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [15:0] wdata = 16'd0;
    logic [15:0] rdata;
    logic        wdog_rst, wdog_irq_n;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit done = 0;

    winwdog_top #(.PULSE_LEN(PLS)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .wdog_rst(wdog_rst), .wdog_irq_n(wdog_irq_n)
    );

    always #4 clk = ~clk;

    // behavioural reference state
    int m_cnt, m_div, m_min, m_pls, m_pre, m_ps;
    bit m_lock, m_mode, m_dis, m_flag, m_armed, m_first, m_kind, m_sts;

    function automatic int exp_of(int pre, int ps);
        int e;
        if (pre >= 8) e = pre - 7;
        else if (pre >= 4) e = 9;
        else e = 9 + pre;
        if (ps >= 2) e = e + ps - 1;
        return e;
    endfunction

    function automatic int m_read(int a);
        case (a)
            0: return m_lock + 2 * m_mode + 4 * m_sts;
            1: return m_cnt;
            2, 3: return m_dis + 2 * m_flag + (m_ps << 6) + (m_pre << 9);
            4: return m_min + 256 * m_first;
            default: return 0;
        endcase
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // reference model step on each rising edge
    always @(posedge clk) begin
        int lim;
        bit tick, wst, wkey, wctl, wwin, ctl_ok, svc, early, ovf, evt, start;
        if (!rst_n) begin
            m_cnt = 0; m_div = 0; m_min = 0; m_pls = 0; m_pre = 0; m_ps = 0;
            m_lock = 1; m_mode = 0; m_dis = 0; m_flag = 0; m_armed = 0;
            m_first = 0; m_kind = 0; m_sts = 1;
        end else begin
            lim  = (1 << exp_of(m_pre, m_ps)) - 1;
            tick = !m_dis && (m_div >= lim);
            wst  = wr_en && addr == 0;
            wkey = wr_en && addr == 2;
            wctl = wr_en && addr == 3;
            wwin = wr_en && addr == 4;
            ctl_ok = wctl && wdata[5:3] == 3'b101;
            svc   = wkey && wdata[7:0] == 8'hAA && m_armed;
            early = svc && (m_cnt < m_min);
            ovf   = tick && m_cnt == 255 && !svc;
            evt   = !m_dis && (ovf || early || (wctl && !ctl_ok));
            start = evt && m_pls == 0;
            m_sts = !(m_pls > 0 && m_kind);
            // flag: clear request then set wins
            if (ctl_ok && wdata[1]) m_flag = 0;
            if (start && !m_mode) m_flag = 1;
            if (start) begin m_pls = PLS; m_kind = m_mode; end
            else if (m_pls > 0) m_pls = m_pls - 1;
            if (m_dis || svc) m_cnt = 0;
            else if (tick) m_cnt = (m_cnt + 1) % 256;
            if (m_dis || tick) m_div = 0; else m_div = m_div + 1;
            if (ctl_ok) begin
                m_ps = wdata[8:6]; m_pre = wdata[12:9];
                if (m_lock) m_dis = wdata[0];
            end
            if (wst) begin
                if (wdata[0]) m_lock = 0;
                m_mode = wdata[1];
            end
            if (wkey) m_armed = (wdata[7:0] == 8'h55);
            if (wwin) m_min = wdata[7:0];
            if (m_min == 0) m_first = 0;
            else if (svc) m_first = 1;
        end
    end

    // per-cycle comparison against the model, away from the edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R8 wdog_rst", wdog_rst, (m_pls > 0 && !m_kind));
            check("R8 wdog_irq_n", wdog_irq_n, !(m_pls > 0 && m_kind));
            case (addr)
                0: check("R6 status read", rdata, m_read(0));
                1: check("R1 counter read", rdata, m_read(1));
                2: check("R11 key read", rdata, m_read(2));
                3: check("R5 control read", rdata, m_read(3));
                default: check("R10 window read", rdata, m_read(4));
            endcase
        end
    end

    // watchdog for a hung run
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic wr(int a, int d);
        @(negedge clk); #1;
        wr_en = 1; addr = 3'(a); wdata = 16'(d);
        @(negedge clk); #1;
        wr_en = 0;
    endtask

    task automatic rd(int a, output int v);
        @(negedge clk); #1;
        addr = 3'(a);
        #1 v = rdata;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic service();
        wr(2, 16'h55); wr(2, 16'hAA);
    endtask

    initial begin
        int v, n;
        idle(4); #1 rst_n = 1;
        // reset state
        rd(0, v); check("R6 lock/mode/status reset", v, 5);
        rd(3, v); check("R7 control reset enabled", v, 0);
        rd(4, v); check("R10 window reset", v, 0);
        rd(1, v); check("R1 counter reset", v, 0);
        // fast divider: E = 1
        wr(3, 16'h1068);
        rd(3, v); check("R5 check bits read 0", v, 16'h1040);
        rd(2, v); check("R11 key reads control", v, 16'h1040);
        idle(40);
        rd(1, v); check("R1 counter advancing", v, m_cnt); check("R1 counter nonzero", v > 10, 1);
        // key sequences
        service();
        rd(1, v); check("R3 service clears", v <= 2, 1);
        idle(20);
        wr(2, 16'hAA);
        rd(1, v); check("R3 unarmed AA ignored", v > 5, 1);
        wr(2, 16'h55); wr(2, 16'h12); wr(2, 16'hAA);
        rd(1, v); check("R3 disarmed AA ignored", v > 5, 1);
        wr(2, 16'h55); wr(2, 16'h55); wr(2, 16'hAA);
        rd(1, v); check("R3 repeated arm then fire", v <= 2, 1);
        // overflow in reset mode
        n = 0;
        while (!wdog_rst && n < 1000) begin @(negedge clk); #2; n++; end
        check("R2 overflow raises reset", wdog_rst, 1);
        check("R2 interrupt idle in reset mode", wdog_irq_n, 1);
        n = 0;
        while (wdog_rst && n < 1000) begin @(negedge clk); #2; n++; end
        check("R8 pulse length", n, PLS);
        rd(3, v); check("R9 flag set", (v >> 1) & 1, 1);
        wr(3, 16'h1068);
        rd(3, v); check("R9 write 0 keeps flag", (v >> 1) & 1, 1);
        wr(3, 16'h106A);
        rd(3, v); check("R9 write 1 clears flag", v, 16'h1040);
        // interrupt mode, bad check bits
        wr(0, 16'h2);
        rd(0, v); check("R2 mode bit set", v, 7);
        service();
        wr(3, 16'h1040);
        idle(2);
        check("R5 bad check raises irq", wdog_irq_n, 0);
        check("R8 reset idle in irq mode", wdog_rst, 0);
        rd(0, v); check("R8 status shows irq low", (v >> 2) & 1, 0);
        rd(3, v); check("R5 bad write discarded", v, 16'h1040);
        idle(40);
        rd(3, v); check("R9 irq kind leaves flag", (v >> 1) & 1, 0);
        // window
        service();
        wr(4, 100);
        rd(4, v); check("R10 first clear before key", v, 100);
        service();
        idle(2);
        check("R4 early service raises event", wdog_irq_n, 0);
        rd(4, v); check("R10 first key flagged", v, 356);
        idle(220);
        rd(1, v); check("R4 counter past threshold", v >= 100, 1);
        service();
        idle(3);
        check("R4 late service accepted", wdog_irq_n, 1);
        wr(4, 0);
        rd(4, v); check("R10 first clears with threshold", v, 0);
        service(); service();
        idle(3);
        check("R4 no window at zero", wdog_irq_n, 1);
        rd(4, v); check("R10 first stays 0 at zero", v, 0);
        // disable
        wr(3, 16'h1069);
        idle(30);
        rd(1, v); check("R7 counter held when disabled", v, 0);
        wr(3, 16'h1041);
        idle(3);
        check("R7 no event when disabled", wdog_irq_n, 1);
        rd(3, v); check("R7 disabled control", v, 16'h1041);
        wr(3, 16'h1068);
        // lock
        wr(0, 16'h3);
        rd(0, v); check("R6 lock cleared", v, 6);
        wr(0, 16'h2);
        rd(0, v); check("R6 writing 0 keeps lock closed", v, 6);
        wr(3, 16'h1069);
        rd(3, v); check("R6 disable frozen", v, 16'h1040);
        idle(20);
        rd(1, v); check("R6 still counting", v > 0, 1);
        // slow divider: E = 4 + 2
        wr(3, 16'h16E8);
        service();
        idle(200);
        rd(1, v); check("R1 slow divider count", v, m_cnt);
        check("R1 slow divider value", v, 3);
        // unused pre-divider code acts as E = 9
        wr(3, 16'h0A28);
        service();
        idle(600);
        rd(1, v); check("R1 unused code count", v, 1);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule